// File: doc/BRIEF.md
# Register-File Page Table Translator

This block turns a logical address into a physical address. It uses a page table held entirely in flip-flops, so a lookup takes no memory access. The upper bits of the logical address select one table entry directly. That entry supplies a frame number, and the lower bits pass through untouched as the offset inside the frame. Each entry also carries a presence flag and a write-protect flag. A separate length register states how many page numbers the running process may use.

When a new process is dispatched, the scheduler reloads every table entry through the load port and writes the length register. After that, each translate request returns a registered response one clock later. The response holds either the physical address or a 2-bit trap cause. The address width, physical width and page size are parameters. The defaults are 16-bit addresses and 8 KB pages, which gives eight entries. A 14-bit space with 2 KB pages also gives eight entries.

Top module: `pgx_top`

## Requirements
- R1: After reset, `rsp_vld` is 0, every entry is marked not present and the length register is 0. A request made before any loading therefore traps with cause 2'b01.
- R2: Each cycle with `req_vld` high produces exactly one cycle of `rsp_vld` high on the following clock edge. A cycle without a request produces `rsp_vld`, `rsp_trap` and `rsp_code` all 0 on the next edge.
- R3: On success, `rsp_code` is 2'b00 and `rsp_trap` is 0. `rsp_paddr` equals the entry's frame number, placed above the unchanged low `PAGE_BITS` offset bits of `req_addr`.
- R4: A page number (the bits of `req_addr` above `PAGE_BITS`) that is greater than or equal to the length register traps with cause 2'b01, even when its entry is present.
- R5: An in-range page whose entry is not present traps with cause 2'b10.
- R6: A write (`req_wr`=1) to an in-range, present, write-protected page traps with cause 2'b11.
- R7: A read (`req_wr`=0) of a write-protected page translates normally.
- R8: When several causes apply, the length cause (01) wins over not-present (10), and not-present wins over write-protect (11).
- R9: Whenever `rsp_trap` is 1, `rsp_paddr` is all zeros.
- R10: A load-port write to an entry, or a write to the length register, affects requests from the next cycle on. A length equal to the entry count allows every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Write one table entry |
| ld_idx | input | VA_W-PAGE_BITS | Entry index to write |
| ld_frame | input | PA_W-PAGE_BITS | Frame number to store |
| ld_valid | input | 1 | Presence flag to store |
| ld_ro | input | 1 | Write-protect flag to store |
| len_we | input | 1 | Write the length register |
| len_val | input | VA_W-PAGE_BITS+1 | Number of legal pages |
| req_vld | input | 1 | Translate request strobe |
| req_addr | input | VA_W | Logical address |
| req_wr | input | 1 | 1 = write access, 0 = read |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address (zero on trap) |
| rsp_trap | output | 1 | Request was refused |
| rsp_code | output | 2 | 00 ok, 01 beyond length, 10 not present, 11 write to protected page |

## Verification
A vector table is walked back to back. It covers reads and writes to open pages, protected pages, a not-present page that is also protected, and a present page above the length bound. Together these separate each trap cause and show which way the priority falls. The frames are chosen so that every page maps to a different frame, which shows both the frame lookup and the offset pass-through. Directed steps then cover four cases: a request straight after reset, a length equal to the entry count, a shrunk length masking a page that would otherwise trap for a lower-priority cause, and an entry rewritten between requests.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
   typedef enum logic [1:0] {
      PGX_OK  = 2'b00,
      PGX_LEN = 2'b01,
      PGX_INV = 2'b10,
      PGX_RO  = 2'b11
   } pgx_cause_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
   parameter int PN_W = 3,
   parameter int FN_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_en,
   input  logic [PN_W-1:0] ld_idx,
   input  logic [FN_W-1:0] ld_frame,
   input  logic            ld_valid,
   input  logic            ld_ro,
   input  logic [PN_W-1:0] rd_idx,
   output logic [FN_W-1:0] rd_frame,
   output logic            rd_valid,
   output logic            rd_ro
);
   localparam int ENTRIES = 1 << PN_W;
   localparam int ENT_W   = FN_W + 2;

   logic [ENT_W-1:0] ent_w [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [ENT_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (ld_en && (ld_idx == PN_W'(e)))
            ent_q <= {ld_valid, ld_ro, ld_frame};
      end
      assign ent_w[e] = ent_q;
   end

   assign {rd_valid, rd_ro, rd_frame} = ent_w[rd_idx];
endmodule

// File: rtl/pgx_guard.sv
module pgx_guard
   import pgx_pkg::*;
#(
   parameter int PN_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            len_we,
   input  logic [PN_W:0]   len_val,
   input  logic [PN_W-1:0] page,
   input  logic            ent_valid,
   input  logic            ent_ro,
   input  logic            wr,
   output pgx_cause_e      cause,
   output logic [PN_W:0]   len_cur
);
   logic [PN_W:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (len_we)
         len_q <= len_val;
   end

   assign len_cur = len_q;

   always_comb begin
      if ({1'b0, page} >= len_q)
         cause = PGX_LEN;
      else if (!ent_valid)
         cause = PGX_INV;
      else if (ent_ro && wr)
         cause = PGX_RO;
      else
         cause = PGX_OK;
   end
endmodule

// File: rtl/pgx_top.sv
module pgx_top
   import pgx_pkg::*;
#(
   parameter int VA_W      = 16,
   parameter int PA_W      = 16,
   parameter int PAGE_BITS = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_en,
   input  logic [VA_W-PAGE_BITS-1:0] ld_idx,
   input  logic [PA_W-PAGE_BITS-1:0] ld_frame,
   input  logic                      ld_valid,
   input  logic                      ld_ro,
   input  logic                      len_we,
   input  logic [VA_W-PAGE_BITS:0]   len_val,
   input  logic                      req_vld,
   input  logic [VA_W-1:0]           req_addr,
   input  logic                      req_wr,
   output logic                      rsp_vld,
   output logic [PA_W-1:0]           rsp_paddr,
   output logic                      rsp_trap,
   output logic [1:0]                rsp_code
);
   localparam int PN_W = VA_W - PAGE_BITS;
   localparam int FN_W = PA_W - PAGE_BITS;

   initial begin
      if (PAGE_BITS < 1 || PAGE_BITS >= VA_W)
         $error("pgx_top: PAGE_BITS must lie in 1..VA_W-1");
      if (PA_W <= PAGE_BITS)
         $error("pgx_top: PA_W must exceed PAGE_BITS");
      if (PN_W > 10)
         $error("pgx_top: register table limited to 1024 entries");
   end

   logic [PN_W-1:0] page;
   logic [FN_W-1:0] ent_frame;
   logic            ent_valid;
   logic            ent_ro;
   pgx_cause_e      cause;
   logic [PN_W:0]   len_cur;

   assign page = req_addr[VA_W-1:PAGE_BITS];

   pgx_table #(.PN_W(PN_W), .FN_W(FN_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_idx   (ld_idx),
      .ld_frame (ld_frame),
      .ld_valid (ld_valid),
      .ld_ro    (ld_ro),
      .rd_idx   (page),
      .rd_frame (ent_frame),
      .rd_valid (ent_valid),
      .rd_ro    (ent_ro)
   );

   pgx_guard #(.PN_W(PN_W)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_we    (len_we),
      .len_val   (len_val),
      .page      (page),
      .ent_valid (ent_valid),
      .ent_ro    (ent_ro),
      .wr        (req_wr),
      .cause     (cause),
      .len_cur   (len_cur)
   );

   pgx_cause_e      code_q;
   logic [PA_W-1:0] paddr_q;
   logic            vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         code_q  <= PGX_OK;
         paddr_q <= '0;
      end else begin
         vld_q <= req_vld;
         if (req_vld) begin
            code_q  <= cause;
            paddr_q <= (cause == PGX_OK) ? {ent_frame, req_addr[PAGE_BITS-1:0]} : '0;
         end else begin
            code_q  <= PGX_OK;
            paddr_q <= '0;
         end
      end
   end

   assign rsp_vld   = vld_q;
   assign rsp_paddr = paddr_q;
   assign rsp_code  = code_q;
   assign rsp_trap  = (code_q != PGX_OK);
endmodule

// File: rtl/pgx_sva.sv
module pgx_sva #(
   parameter int VA_W      = 16,
   parameter int PA_W      = 16,
   parameter int PAGE_BITS = 13
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_vld,
   input logic [VA_W-1:0]         req_addr,
   input logic                    req_wr,
   input logic                    rsp_vld,
   input logic [PA_W-1:0]         rsp_paddr,
   input logic                    rsp_trap,
   input logic [1:0]              rsp_code,
   input logic [VA_W-PAGE_BITS:0] len_cur
);
   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!rsp_vld && !rsp_trap && rsp_code == 2'b00));

   a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (rsp_trap || rsp_paddr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

   a_r4_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && ({1'b0, req_addr[VA_W-1:PAGE_BITS]} >= len_cur)) |=> rsp_code == 2'b01);

   a_r6_protect_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_wr) |=> rsp_code != 2'b11);

   a_r9_trap_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> rsp_paddr == '0);
endmodule

bind pgx_top pgx_sva #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_addr  (req_addr),
   .req_wr    (req_wr),
   .rsp_vld   (rsp_vld),
   .rsp_paddr (rsp_paddr),
   .rsp_trap  (rsp_trap),
   .rsp_code  (rsp_code),
   .len_cur   (len_cur)
);

// File: tb/sim_pgx_top.sv
`timescale 1ns/1ps
module sim_pgx_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [2:0]  ld_frame = '0;
   logic        ld_valid = 1'b0;
   logic        ld_ro = 1'b0;
   logic        len_we = 1'b0;
   logic [3:0]  len_val = '0;
   logic        req_vld = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic        rsp_vld;
   logic [15:0] rsp_paddr;
   logic        rsp_trap;
   logic [1:0]  rsp_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pgx_top u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_frame(ld_frame), .ld_valid(ld_valid), .ld_ro(ld_ro),
      .len_we(len_we), .len_val(len_val), .req_vld(req_vld),
      .req_addr(req_addr), .req_wr(req_wr), .rsp_vld(rsp_vld),
      .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap), .rsp_code(rsp_code)
   );

   // {addr, wr, expected code}; table: page p -> frame 7-p, page 5 absent,
   // pages 2,3,5 write-protected, length 7
   localparam logic [18:0] VEC [0:10] = '{
      {16'h0123, 1'b0, 2'b00},   // R3
      {16'h2ABC, 1'b1, 2'b00},   // R3
      {16'h4000, 1'b0, 2'b00},   // R7
      {16'h5FFF, 1'b1, 2'b11},   // R6
      {16'h6001, 1'b1, 2'b11},   // R6
      {16'h8F00, 1'b0, 2'b00},   // R3
      {16'hA010, 1'b0, 2'b10},   // R5
      {16'hA010, 1'b1, 2'b10},   // R8 absent beats protect
      {16'hC777, 1'b1, 2'b00},   // R3
      {16'hE000, 1'b0, 2'b01},   // R4
      {16'hFFFF, 1'b1, 2'b01}    // R4
   };

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_rsp(input string req, input logic [1:0] code, input logic [15:0] pa);
      chk({req, " vld"}, 32'(rsp_vld), 32'd1);
      chk({req, " code"}, 32'(rsp_code), 32'(code));
      chk({req, " trap"}, 32'(rsp_trap), 32'(code != 2'b00));
      chk({req, " paddr"}, 32'(rsp_paddr), 32'(pa));
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic one_req(input logic [15:0] a, input logic w);
      req_vld = 1'b1; req_addr = a; req_wr = w;
      step;
      req_vld = 1'b0; req_wr = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run;
   end

   initial begin
      step; step;
      chk("R1 vld in reset", 32'(rsp_vld), 32'd0);
      rst_n = 1'b1;
      step;
      chk("R1 vld after reset", 32'(rsp_vld), 32'd0);
      one_req(16'h0000, 1'b0);
      chk_rsp("R1 unloaded", 2'b01, 16'h0000);

      for (int p = 0; p < 8; p++) begin
         ld_en = 1'b1; ld_idx = 3'(p); ld_frame = 3'(7 - p);
         ld_valid = (p != 5); ld_ro = (p == 2 || p == 3 || p == 5);
         step;
      end
      ld_en = 1'b0;
      len_we = 1'b1; len_val = 4'd7; step; len_we = 1'b0;

      // back-to-back walk: each response sampled while the next request is driven
      for (int i = 0; i < 11; i++) begin
         logic [15:0] a;
         logic [1:0]  c;
         logic [15:0] pa;
         a = VEC[i][18:3];
         c = VEC[i][1:0];
         pa = (c == 2'b00) ? {3'(7 - a[15:13]), a[12:0]} : 16'h0000;
         req_vld = 1'b1; req_addr = a; req_wr = VEC[i][2];
         step;
         chk_rsp($sformatf("R2/R3-R9 vec%0d", i), c, pa);
      end
      req_vld = 1'b0; req_wr = 1'b0;
      step;
      chk("R2 idle vld", 32'(rsp_vld), 32'd0);
      chk("R2 idle code", 32'(rsp_code), 32'd0);

      // R10 full length allows the top page
      len_we = 1'b1; len_val = 4'd8; step; len_we = 1'b0;
      one_req(16'hFFFF, 1'b0);
      chk_rsp("R10 full length", 2'b00, 16'h1FFF);

      // R8 length beats absent+protect on page 5
      len_we = 1'b1; len_val = 4'd5; step; len_we = 1'b0;
      one_req(16'hA010, 1'b1);
      chk_rsp("R8 length first", 2'b01, 16'h0000);
      one_req(16'h8001, 1'b1);
      chk_rsp("R4 page below length", 2'b00, 16'h6001);

      // R10 entry rewrite takes effect next cycle
      ld_en = 1'b1; ld_idx = 3'd0; ld_frame = 3'd2; ld_valid = 1'b1; ld_ro = 1'b1;
      step; ld_en = 1'b0;
      one_req(16'h0123, 1'b0);
      chk_rsp("R10 reload read", 2'b00, 16'h4123);
      one_req(16'h0123, 1'b1);
      chk_rsp("R6 reload write", 2'b11, 16'h0000);

      // R1 reset clears table and length
      rst_n = 1'b0; step; rst_n = 1'b1; step;
      one_req(16'h0123, 1'b0);
      chk_rsp("R1 after second reset", 2'b01, 16'h0000);
      len_we = 1'b1; len_val = 4'd8; step; len_we = 1'b0;
      one_req(16'h0123, 1'b0);
      chk_rsp("R1 entries cleared", 2'b10, 16'h0000);

      finish_run;
   end
endmodule